// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block sits on a simple register port and runs one NAND flash operation for each command word that software writes. The command word picks which phases run: a first command byte, one to eight address bytes, a second command byte, a wait on the device ready/busy line, and a data phase. The phases always run in that fixed order, and any phase whose bit is clear is skipped. The address bytes come from two address registers. The second command byte comes from a packed read-opcode register. The data phase moves a programmed number of bytes between the 8-bit device bus and a 1024-byte internal buffer, and the host reaches that buffer as little-endian 32-bit words.

On the device side the block drives chip-enable, command-latch, address-latch, write and read strobes. Each strobe is held active for a programmable number of clock cycles and then released for another programmable number. Software learns that an operation has finished by polling a completion flag, which it clears by writing 1 to it. A sticky error flag records any command word written while an operation was still running.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, CTRL (0x00) and STAT (0x04) read 0 and TIMING (0x0C) reads 0x22. Chip-enable, write strobe and read strobe are high, and command-latch and address-latch are low.
- R2: The phases run in the order first command, address, second command, ready wait, data. A phase whose command-word bit is clear is skipped: first command bit 22, address bit 19, second command bit 24, wait bit 23, data bit 21.
- R3: The first command byte is command-word bits 7:0. The second command byte is bits 7:0 of the read-opcode register (0x28). Both are latched with command-latch high and address-latch low.
- R4: Command-word bits 18:16 plus one sets the number of address bytes. Byte i is byte i of {ADDR_HI (0x18), ADDR_LO (0x14)}, sent low byte first, with address-latch high.
- R5: At the end of an operation STAT bit 1 (done) is set. Writing 1 to that bit clears it.
- R6: STAT bit 3 is high while an operation runs. A command write (0x24) during that time is ignored and sets the sticky STAT bit 4, which is cleared by writing 1 to it.
- R7: While CTRL bit 0 (enable) is 0, command writes are ignored. No strobe toggles and no status bit changes.
- R8: Writing 1 to CTRL bit 1 aborts any running operation and clears the done and error bits. The bit returns to 0 by itself one cycle later, and all device pins return to idle.
- R9: Every strobe stays low for S cycles and then high for H cycles, with S = TIMING[3:0] and H = TIMING[7:4]. A value of 0 counts as 1. An operation without a wait lasts exactly bytes*(S+H) cycles of chip-enable.
- R10: The ready wait first waits until ready/busy is low or 16 cycles have passed, then waits until ready/busy is high. No data strobe occurs before that.
- R11: With command-word bit 20 = 0, the data phase pulses the read strobe COUNT (0x20) times. The byte sampled in the last low cycle of pulse k is stored at buffer byte k, and buffer word w reads at 0x400+4w with byte 0 in bits 7:0.
- R12: With bit 20 = 1, the data phase drives buffer bytes 0..COUNT-1 with the write strobe while both latch lines are low. Host writes to 0x400+4w fill the buffer.
- R13: A data phase with COUNT = 0 moves no bytes, and the operation still sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register or buffer write strobe |
| host_addr | input | 11 | Byte address; bit 10 selects the buffer |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Bus data out |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_i | input | 8 | Bus data in |
| nf_rb | input | 1 | Ready (1) / busy (0) |

## Verification
A wrong phase state shows up on the next strobe edge as a byte with the wrong latch kind or the wrong value in the order the device captures. A wrong strobe timer changes the pulse width or the length of the chip-enable window within one byte time. A bad ready-wait state starts read strobes while ready/busy is still low, or keeps chip-enable low after 16 idle cycles. A lost status update appears at the very next status read.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  // Sequencer phases; numeric order is the execution order.
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0, ST_CMD1 = 3'd1, ST_ADDR = 3'd2, ST_CMD2 = 3'd3,
    ST_WLO  = 3'd4, ST_WHI  = 3'd5, ST_DATA = 3'd6
  } seq_st_e;

  localparam int CW_ANUM = 16;
  localparam int CW_SADR = 19;
  localparam int CW_DIR  = 20;
  localparam int CW_DATA = 21;
  localparam int CW_CMD1 = 22;
  localparam int CW_WAIT = 23;
  localparam int CW_CMD2 = 24;

  localparam logic [7:0] RG_CTRL = 8'h00;
  localparam logic [7:0] RG_STAT = 8'h04;
  localparam logic [7:0] RG_TIME = 8'h0C;
  localparam logic [7:0] RG_ALO  = 8'h14;
  localparam logic [7:0] RG_AHI  = 8'h18;
  localparam logic [7:0] RG_CNT  = 8'h20;
  localparam logic [7:0] RG_CMD  = 8'h24;
  localparam logic [7:0] RG_RCMD = 8'h28;
endpackage

// File: rtl/nfs_buf.sv
module nfs_buf #(
  parameter int BUF_BYTES = 1024,
  localparam int IDX_W = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             h_we,
  input  logic [IDX_W-3:0] h_widx,
  input  logic [31:0]      h_wdata,
  output logic [31:0]      h_rdata,
  input  logic             b_we,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [7:0]       b_wdata,
  output logic [7:0]       b_rdata
);
  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (h_we) begin
      for (int l = 0; l < 4; l++) mem[{h_widx, 2'(l)}] <= h_wdata[8*l +: 8];
    end
    if (b_we) mem[b_idx] <= b_wdata;
  end

  always_comb begin
    for (int l = 0; l < 4; l++) h_rdata[8*l +: 8] = mem[{h_widx, 2'(l)}];
  end
  assign b_rdata = mem[b_idx];
endmodule

// File: rtl/nfs_seq.sv
module nfs_seq
  import nfs_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int RDY_WIN = 16,
  localparam int CNT_W = IDX_W + 1,
  localparam int TMR_W = ($clog2(RDY_WIN) > 4) ? $clog2(RDY_WIN) : 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             start,
  input  logic [31:0]      cmd_word,
  input  logic [63:0]      addr_src,
  input  logic [7:0]       cmd2_op,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic [3:0]       t_setup,
  input  logic [3:0]       t_hold,
  input  logic             rb_i,
  input  logic [7:0]       dq_i,
  input  logic [7:0]       buf_rdata,
  output logic             busy,
  output logic             done,
  output logic             buf_we,
  output logic [IDX_W-1:0] buf_idx,
  output logic             nf_ce_n,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dq_o,
  output logic             nf_dq_oe
);
  seq_st_e          st, st_n;
  logic             ph, ph_n;
  logic [TMR_W-1:0] tmr, tmr_n, es, eh;
  logic [CNT_W-1:0] idx, idx_n, cnt_q;
  logic [31:0]      cw_q;
  logic [1:0]       rb_sync;
  logic             rb_s, byte_ph, last_b, wr_dir;

  // First enabled phase at or after level lvl.
  function automatic seq_st_e pick(input logic [2:0] lvl, input logic [31:0] cw,
                                   input logic cnt_nz);
    if (lvl <= 3'd1 && cw[CW_CMD1]) return ST_CMD1;
    if (lvl <= 3'd2 && cw[CW_SADR]) return ST_ADDR;
    if (lvl <= 3'd3 && cw[CW_CMD2]) return ST_CMD2;
    if (lvl <= 3'd4 && cw[CW_WAIT]) return ST_WLO;
    if (lvl <= 3'd6 && cw[CW_DATA] && cnt_nz) return ST_DATA;
    return ST_IDLE;
  endfunction

  assign rb_s    = rb_sync[1];
  assign es      = (t_setup == 4'd0) ? TMR_W'(1) : TMR_W'(t_setup);
  assign eh      = (t_hold  == 4'd0) ? TMR_W'(1) : TMR_W'(t_hold);
  assign byte_ph = (st == ST_CMD1) || (st == ST_ADDR) || (st == ST_CMD2) || (st == ST_DATA);
  assign wr_dir  = cw_q[CW_DIR];

  always_comb begin
    unique case (st)
      ST_ADDR: last_b = (idx == CNT_W'(cw_q[CW_ANUM +: 3]));
      ST_DATA: last_b = (idx == cnt_q - CNT_W'(1));
      default: last_b = 1'b1;
    endcase
  end

  // Next-state logic
  always_comb begin
    st_n = st; ph_n = ph; tmr_n = tmr; idx_n = idx;
    done = 1'b0; buf_we = 1'b0;
    if (st == ST_IDLE) begin
      if (start) begin
        st_n = pick(3'd1, cmd_word, xfer_cnt != '0);
        ph_n = 1'b0; tmr_n = '0; idx_n = '0;
        done = (st_n == ST_IDLE);
      end
    end else if (st == ST_WLO) begin
      if (!rb_s || tmr == TMR_W'(RDY_WIN - 1)) begin
        st_n = ST_WHI; tmr_n = '0;
      end else begin
        tmr_n = tmr + TMR_W'(1);
      end
    end else if (st == ST_WHI) begin
      if (rb_s) begin
        st_n = pick(3'd6, cw_q, cnt_q != '0);
        done = (st_n == ST_IDLE);
      end
    end else if (!ph) begin
      if (tmr == es - TMR_W'(1)) begin
        ph_n = 1'b1; tmr_n = '0;
        buf_we = (st == ST_DATA) && !wr_dir;
      end else begin
        tmr_n = tmr + TMR_W'(1);
      end
    end else if (tmr == eh - TMR_W'(1)) begin
      ph_n = 1'b0; tmr_n = '0;
      if (last_b) begin
        st_n = pick(3'(st) + 3'd1, cw_q, cnt_q != '0);
        idx_n = '0;
        done = (st_n == ST_IDLE);
      end else begin
        idx_n = idx + CNT_W'(1);
      end
    end else begin
      tmr_n = tmr + TMR_W'(1);
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= 1'b0; tmr <= '0; idx <= '0;
      cw_q <= '0; cnt_q <= '0; rb_sync <= 2'b11;
    end else begin
      rb_sync <= {rb_sync[0], rb_i};
      if (soft_rst) begin
        st <= ST_IDLE; ph <= 1'b0; tmr <= '0; idx <= '0;
      end else begin
        st <= st_n; ph <= ph_n; tmr <= tmr_n; idx <= idx_n;
      end
      if (start && st == ST_IDLE) begin
        cw_q  <= cmd_word;
        cnt_q <= xfer_cnt;
      end
    end
  end

  // Device pins
  assign busy     = (st != ST_IDLE);
  assign buf_idx  = idx[IDX_W-1:0];
  assign nf_ce_n  = (st == ST_IDLE);
  assign nf_cle   = (st == ST_CMD1) || (st == ST_CMD2);
  assign nf_ale   = (st == ST_ADDR);
  assign nf_we_n  = !(byte_ph && !ph && (st != ST_DATA || wr_dir));
  assign nf_re_n  = !(byte_ph && !ph && st == ST_DATA && !wr_dir);
  assign nf_dq_oe = byte_ph && (st != ST_DATA || wr_dir);

  always_comb begin
    unique case (st)
      ST_CMD1: nf_dq_o = cw_q[7:0];
      ST_CMD2: nf_dq_o = cmd2_op;
      ST_ADDR: nf_dq_o = addr_src[{idx[2:0], 3'b000} +: 8];
      ST_DATA: nf_dq_o = buf_rdata;
      default: nf_dq_o = 8'h00;
    endcase
  end

  // R2: phases never move backwards within one operation
  a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st != ST_IDLE && $past(st) != ST_IDLE) |-> (st >= $past(st)));
  // R4: address byte index stays within the programmed count
  a_r4_addr_bound: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st == ST_ADDR) |-> (idx <= CNT_W'(cw_q[CW_ANUM +: 3])));
  // R10: the second wait stage holds while the device is busy
  a_r10_wait_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (st == ST_WHI && !rb_s) |=> (st == ST_WHI));
  // R11: the bus is never driven while the read strobe is low
  a_r11_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_dq_oe);
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nfs_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int RDY_WIN   = 16,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int HA_W  = IDX_W + 1,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic [HA_W-1:0] host_addr,
  input  logic [31:0]     host_wdata,
  output logic [31:0]     host_rdata,
  output logic            nf_ce_n,
  output logic            nf_cle,
  output logic            nf_ale,
  output logic            nf_we_n,
  output logic            nf_re_n,
  output logic [7:0]      nf_dq_o,
  output logic            nf_dq_oe,
  input  logic [7:0]      nf_dq_i,
  input  logic            nf_rb
);
  logic             en, ctl_rst, done_q, err_q, done_n, err_n;
  logic [7:0]       timing;
  logic [31:0]      addr_lo, addr_hi, rcmd;
  logic [CNT_W-1:0] cnt;
  logic             in_buf, busy, seq_done, buf_we, start, cmd_wr, stat_wr;
  logic [IDX_W-1:0] buf_idx;
  logic [7:0]       buf_rd;
  logic [31:0]      buf_hrd;
  logic [7:0]       roff;

  assign in_buf  = host_addr[HA_W-1];
  assign roff    = host_addr[7:0];
  assign cmd_wr  = host_wr && !in_buf && roff == RG_CMD;
  assign stat_wr = host_wr && !in_buf && roff == RG_STAT;
  assign start   = cmd_wr && en && !busy && !ctl_rst;

  // Status next-state
  always_comb begin
    done_n = done_q & ~(stat_wr & host_wdata[1]);
    err_n  = err_q  & ~(stat_wr & host_wdata[4]);
    if (seq_done) done_n = 1'b1;
    if (cmd_wr && busy) err_n = 1'b1;
    if (ctl_rst) begin
      done_n = 1'b0; err_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; ctl_rst <= 1'b0; timing <= 8'h22;
      addr_lo <= '0; addr_hi <= '0; rcmd <= '0; cnt <= '0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q  <= done_n;
      err_q   <= err_n;
      ctl_rst <= host_wr && !in_buf && roff == RG_CTRL && host_wdata[1];
      if (host_wr && !in_buf && roff == RG_CTRL) en      <= host_wdata[0];
      if (host_wr && !in_buf && roff == RG_TIME) timing  <= host_wdata[7:0];
      if (host_wr && !in_buf && roff == RG_ALO)  addr_lo <= host_wdata;
      if (host_wr && !in_buf && roff == RG_AHI)  addr_hi <= host_wdata;
      if (host_wr && !in_buf && roff == RG_RCMD) rcmd    <= host_wdata;
      if (host_wr && !in_buf && roff == RG_CNT)  cnt     <= host_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    host_rdata = '0;
    if (in_buf) host_rdata = buf_hrd;
    else begin
      unique case (roff)
        RG_CTRL: host_rdata = {30'b0, ctl_rst, en};
        RG_STAT: host_rdata = {27'b0, err_q, busy, 1'b0, done_q, 1'b0};
        RG_TIME: host_rdata = {24'b0, timing};
        RG_ALO:  host_rdata = addr_lo;
        RG_AHI:  host_rdata = addr_hi;
        RG_CNT:  host_rdata = {{(32-CNT_W){1'b0}}, cnt};
        RG_RCMD: host_rdata = rcmd;
        default: host_rdata = '0;
      endcase
    end
  end

  nfs_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .h_we(host_wr && in_buf), .h_widx(host_addr[IDX_W-1:2]),
    .h_wdata(host_wdata), .h_rdata(buf_hrd),
    .b_we(buf_we), .b_idx(buf_idx), .b_wdata(nf_dq_i), .b_rdata(buf_rd));

  nfs_seq #(.IDX_W(IDX_W), .RDY_WIN(RDY_WIN)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(ctl_rst), .start(start),
    .cmd_word(host_wdata), .addr_src({addr_hi, addr_lo}), .cmd2_op(rcmd[7:0]),
    .xfer_cnt(cnt), .t_setup(timing[3:0]), .t_hold(timing[7:4]),
    .rb_i(nf_rb), .dq_i(nf_dq_i), .buf_rdata(buf_rd),
    .busy(busy), .done(seq_done), .buf_we(buf_we), .buf_idx(buf_idx),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe));

  // R5: done only rises after an operation ran or was started
  a_r5_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(busy) || $past(start)));
  // R6: a command written while busy flags the error
  a_r6_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy && !ctl_rst) |=> err_q);
  // R7: a command written while disabled starts nothing
  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !en && !busy) |=> !busy);
  // R8: soft reset leaves the sequencer idle and clears itself
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |=> (!busy && !ctl_rst));
endmodule

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [10:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0]  nf_dq_o, nf_dq_i;
  logic        nf_rb = 1'b1;

  int checks = 0, fails = 0;
  int lg_n = 0, rd_cnt = 0, width_err = 0, ce_last = 0, ce_falls = 0;
  int we_lo = 0, re_lo = 0, ce_lo = 0, exp_s = 2;
  logic [9:0] lg [512];
  logic [9:0] cap;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign nf_dq_i = 8'(8'h5A + rd_cnt * 7);

  nand_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe),
    .nf_dq_i(nf_dq_i), .nf_rb(nf_rb));

  // Device model: logs bytes on the write strobe's rising edge, counts reads.
  always @(negedge clk) if (rst_n) begin
    if (!nf_we_n) begin
      we_lo++;
      cap = {nf_cle ? 2'd1 : (nf_ale ? 2'd2 : 2'd3), nf_dq_o};
    end else if (we_lo != 0) begin
      if (lg_n < 512) lg[lg_n] = cap;
      lg_n++;
      if (we_lo != exp_s) width_err++;
      we_lo = 0;
    end
    if (!nf_re_n) re_lo++;
    else if (re_lo != 0) begin
      rd_cnt++;
      if (re_lo != exp_s) width_err++;
      re_lo = 0;
    end
    if (!nf_ce_n) begin
      if (ce_lo == 0) ce_falls++;
      ce_lo++;
    end else if (ce_lo != 0) begin
      ce_last = ce_lo;
      ce_lo = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] v);
    @(negedge clk);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(11'h004, v);
      if (!v[3]) break;
    end
    check(!v[3], tag, v[3], 0);
    @(negedge clk);
  endtask

  function automatic logic [9:0] ent(input logic [1:0] k, input logic [7:0] b);
    return {k, b};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] asrc;
    int base, bad;
    asrc = {32'h0000_7766, 32'h4433_2211};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(11'h000, v); check(v == 0, "R1 ctrl", v, 0);
    rd(11'h004, v); check(v == 0, "R1 stat", v, 0);
    rd(11'h00C, v); check(v == 32'h22, "R1 timing", v, 32'h22);
    check({nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale} == 5'b11100, "R1 pins",
          {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 5'b11100);

    // R7 disabled: command ignored
    wr(11'h024, 32'h00C0_0090);
    repeat (4) @(negedge clk);
    rd(11'h004, v); check(v == 0, "R7 stat disabled", v, 0);
    check(ce_falls == 0 && lg_n == 0, "R7 no strobes", lg_n, 0);

    wr(11'h000, 1);
    wr(11'h014, asrc[31:0]);
    wr(11'h018, asrc[63:32]);
    wr(11'h028, 32'h00E0_0530);

    // R3 R4 R2: address count sweep with both commands
    for (int na = 0; na < 8; na++) begin
      base = lg_n;
      wr(11'h024, 32'h0148_0000 | (na << 16));
      wait_done("R4 busy clear");
      bad = 0;
      if (lg[base] != ent(1, 8'h00)) bad++;
      for (int i = 0; i <= na; i++) if (lg[base+1+i] != ent(2, asrc[8*i +: 8])) bad++;
      if (lg[base+na+2] != ent(1, 8'h30)) bad++;
      check(lg_n - base == na + 3, "R4 byte count", lg_n - base, na + 3);
      check(bad == 0, "R3 R4 byte order/value", bad, 0);
      rd(11'h004, v); check(v == 32'h2, "R5 done set", v, 2);
      wr(11'h004, 32'h2);
      rd(11'h004, v); check(v == 0, "R5 done cleared", v, 0);
    end

    // R2 skip: no first command although its opcode field is nonzero
    base = lg_n;
    wr(11'h024, 32'h0109_00AA);
    wait_done("R2 busy clear");
    check(lg_n - base == 3 && lg[base] == ent(2, 8'h11) && lg[base+1] == ent(2, 8'h22)
          && lg[base+2] == ent(1, 8'h30), "R2 skipped phase", lg[base], ent(2, 8'h11));
    wr(11'h004, 32'h12);

    // R9 timing sweep
    for (int s = 0; s < 4; s++) begin
      for (int h = 0; h < 4; h++) begin
        int es, eh, we0;
        es = (s == 0) ? 1 : s; eh = (h == 0) ? 1 : h;
        wr(11'h00C, (h << 4) | s);
        exp_s = es;
        we0 = width_err;
        wr(11'h024, 32'h0149_0000);
        wait_done("R9 busy clear");
        check(ce_last == 4 * (es + eh), "R9 ce window", ce_last, 4 * (es + eh));
        check(width_err == we0, "R9 strobe width", width_err - we0, 0);
      end
    end
    wr(11'h00C, 32'h22); exp_s = 2;
    wr(11'h004, 32'h12);

    // R10 R11 R6: read with ready wait, device busy first
    nf_rb = 1'b0;
    wr(11'h020, 8);
    base = lg_n;
    begin
      int r0;
      r0 = rd_cnt;
      wr(11'h024, 32'h01EC_0000);
      repeat (60) @(negedge clk);
      rd(11'h004, v); check(v[3] == 1'b1, "R6 busy while waiting", v[3], 1);
      check(rd_cnt == r0, "R10 no read before ready", rd_cnt - r0, 0);
      wr(11'h024, 32'h0040_0077);
      rd(11'h004, v); check(v[4] == 1'b1, "R6 error sticky", v[4], 1);
      nf_rb = 1'b1;
      wait_done("R10 busy clear");
      check(rd_cnt - r0 == 8, "R11 read count", rd_cnt - r0, 8);
      check(lg_n - base == 7, "R6 rejected command not run", lg_n - base, 7);
      for (int w = 0; w < 2; w++) begin
        logic [31:0] e;
        for (int b = 0; b < 4; b++) e[8*b +: 8] = 8'(8'h5A + (r0 + 4*w + b) * 7);
        rd(11'h400 + 11'(4*w), v);
        check(v == e, "R11 buffer word", v, e);
      end
    end
    wr(11'h004, 32'h10);
    rd(11'h004, v); check(v == 32'h2, "R6 error cleared", v, 2);
    wr(11'h004, 32'h2);

    // R10 window: device never busy
    wr(11'h024, 32'h00C0_0000);
    wait_done("R10 window busy clear");
    check(ce_last == 21, "R10 window length", ce_last, 21);

    // R12 write data from buffer
    wr(11'h400, 32'h1312_1110);
    wr(11'h404, 32'h1716_1514);
    wr(11'h020, 6);
    base = lg_n;
    begin
      int r0;
      r0 = rd_cnt;
      wr(11'h024, 32'h0078_0080);
      wait_done("R12 busy clear");
      bad = 0;
      if (lg[base] != ent(1, 8'h80)) bad++;
      if (lg[base+1] != ent(2, 8'h11)) bad++;
      for (int i = 0; i < 6; i++) if (lg[base+2+i] != ent(3, 8'(8'h10 + i))) bad++;
      check(lg_n - base == 8 && bad == 0, "R12 write data", bad, 0);
      check(rd_cnt == r0, "R12 no read strobes", rd_cnt - r0, 0);
    end
    wr(11'h004, 32'h12);

    // R13 zero count
    wr(11'h020, 0);
    begin
      int f0, r0;
      f0 = ce_falls; r0 = rd_cnt;
      wr(11'h024, 32'h0020_0000);
      repeat (3) @(negedge clk);
      rd(11'h004, v); check(v == 32'h2, "R13 done with zero count", v, 2);
      check(ce_falls == f0 && rd_cnt == r0, "R13 no transfer", ce_falls - f0, 0);
    end
    wr(11'h004, 32'h12);

    // R8 soft reset during wait
    nf_rb = 1'b0;
    wr(11'h024, 32'h00C0_00FF);
    repeat (10) @(negedge clk);
    wr(11'h000, 32'h3);
    @(negedge clk);
    rd(11'h000, v); check(v == 1, "R8 self clear", v, 1);
    rd(11'h004, v); check(v == 0, "R8 status cleared", v, 0);
    check(nf_ce_n == 1'b1, "R8 pins idle", nf_ce_n, 1);
    nf_rb = 1'b1;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule